// File: doc/BRIEF.md
# Decode-Stage Control Hazard Unit

This block steers the front end of a five-stage in-order pipeline. Jumps and conditional branches are resolved while they sit in decode. The unit works out three things each cycle: whether fetch and the fetch/decode register may advance, whether the word just fetched must become a no-op, and where fetch goes next. It also detects when an instruction in decode needs a value that a load in execute has not yet produced. In that case it holds the front stages in place and sends a bubble into execute, while older instructions keep moving.

The instruction in decode arrives with four pieces of information: its class, the equality result of its two register operands, the direction the fetch predictor chose for it, and its PC+4 with its immediate and jump-index fields. From these the unit computes the branch and jump targets. It drives a next-PC select and the redirect address.

A squash clears the instruction field of the fetch/decode register, which turns the wrong-path word into a no-op. Memory and register writes happen only in the last two stages, so a squashed word never changes architectural state.

Top module: `hz_ctrl_top`

## Requirements
- R1: When `ex_mem_read_i` is 1 and `ex_rt_i` is non-zero and equal to `id_rs_i` or `id_rt_i`, the unit stalls: `pc_we_o`=0, `ifid_we_o`=0, `idex_bubble_o`=1.
- R2: No stall is raised when `ex_mem_read_i` is 0, when `ex_rt_i` is 0, or when `ex_rt_i` matches neither source. In each of these cases `pc_we_o`=1, `ifid_we_o`=1 and `idex_bubble_o`=0.
- R3: A jump (class code 3) that is not stalled sets `ifid_flush_o`=1 and `pc_sel_o`=2. It drives `redirect_pc_o` = {PC+4[31:28], 26-bit index, 2'b00}.
- R4: A branch taken while predicted not-taken sets `ifid_flush_o`=1 and `pc_sel_o`=1. It drives `redirect_pc_o` = PC+4 + (sign-extended 16-bit offset << 2). Class 1 is taken when the operands are equal. Class 2 is taken when they differ.
- R5: A branch that is predicted not-taken and is actually not taken gives `ifid_flush_o`=0 and `pc_sel_o`=0.
- R6: A branch that is predicted taken and is actually taken gives `ifid_flush_o`=0 and `pc_sel_o`=0, because fetch already followed the target.
- R7: A branch that is predicted taken but is actually not taken sets `ifid_flush_o`=1 and `pc_sel_o`=3. It drives `redirect_pc_o` = the decode instruction's PC+4. `redirect_pc_o` also equals PC+4 whenever `pc_sel_o` is 0.
- R8: A load-use stall has priority over any redirect. While stalled, `ifid_flush_o`=0 and `pc_sel_o`=0. The branch or jump resolves on the first cycle after the stall clears.
- R9: `ifid_flush_o` is 1 exactly when `pc_sel_o` is non-zero. It is never 1 together with `idex_bubble_o`.
- R10: Class code 0 (not a control transfer) never flushes or redirects, whatever the values of the equality and prediction inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| id_class_i | input | 2 | Decode class: 0 other, 1 branch-if-equal, 2 branch-if-not-equal, 3 jump |
| id_ops_equal_i | input | 1 | Decode operands compare equal |
| id_pred_taken_i | input | 1 | Fetch predicted this instruction taken |
| id_rs_i | input | 5 | Decode source register 1 |
| id_rt_i | input | 5 | Decode source register 2 |
| id_pc_plus4_i | input | 32 | PC+4 of the decode instruction |
| id_imm_i | input | 16 | Branch offset in words |
| id_jidx_i | input | 26 | Jump word index |
| ex_mem_read_i | input | 1 | Execute-stage instruction is a load |
| ex_rt_i | input | 5 | Execute-stage load destination |
| pc_we_o | output | 1 | PC write enable |
| ifid_we_o | output | 1 | Fetch/decode register write enable |
| ifid_flush_o | output | 1 | Clear fetched instruction field |
| idex_bubble_o | output | 1 | Zero control bits entering execute |
| pc_sel_o | output | 2 | Next PC: 0 sequential, 1 branch target, 2 jump target, 3 fall-through repair |
| redirect_pc_o | output | 32 | Redirect address |

## Verification
The bench covers the following corner cases:
- **Load to register zero.** A unit that stalls here wastes a cycle on every load to register 0.
- **Load whose destination matches only the second source.** A unit that checks only the first source lets stale data through.
- **Stall and branch in the same cycle.** Resolving the redirect during the stall would squash the wrong word or redirect twice.
- **Both misprediction directions.** An inverted taken sense, or a missing repair to PC+4, shows up as the wrong select or the wrong address.
- **Negative branch offset.** A unit that zero-extends the offset sends backward branches far forward.
- **Non-control class with arbitrary compare and prediction inputs.** A unit that decodes the class loosely flushes ordinary instructions.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    CLS_OTHER = 2'd0,
    CLS_BEQ   = 2'd1,
    CLS_BNE   = 2'd2,
    CLS_JMP   = 2'd3
  } id_cls_e;

  typedef enum logic [1:0] {
    SEL_SEQ = 2'd0,
    SEL_BR  = 2'd1,
    SEL_JMP = 2'd2,
    SEL_FIX = 2'd3
  } pc_sel_e;
endpackage

// File: rtl/hz_loaduse.sv
module hz_loaduse #(
  parameter int unsigned REG_AW = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ex_mem_read_i,
  input  logic [REG_AW-1:0] ex_rt_i,
  input  logic [REG_AW-1:0] id_rs_i,
  input  logic [REG_AW-1:0] id_rt_i,
  output logic              stall_o
);
  localparam logic [REG_AW-1:0] ZERO_REG = '0;

  logic dest_live, hit_rs, hit_rt;

  assign dest_live = ex_mem_read_i && (ex_rt_i != ZERO_REG);
  assign hit_rs    = (ex_rt_i == id_rs_i);
  assign hit_rt    = (ex_rt_i == id_rt_i);
  assign stall_o   = dest_live && (hit_rs || hit_rt);

  // R2: the zero register never creates a hazard
  p_zero_dest_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_rt_i == ZERO_REG) |-> !stall_o);
  // R2: a non-load never stalls
  p_no_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ex_mem_read_i |-> !stall_o);
endmodule

// File: rtl/hz_target.sv
module hz_target #(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned IMM_W  = 16,
  parameter int unsigned JIDX_W = 26
) (
  input  logic [XLEN-1:0]   pc_plus4_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [JIDX_W-1:0] jidx_i,
  output logic [XLEN-1:0]   br_tgt_o,
  output logic [XLEN-1:0]   jmp_tgt_o
);
  localparam int unsigned SH     = 2;
  localparam int unsigned EXT_W  = XLEN - IMM_W - SH;
  localparam int unsigned PAGE_W = XLEN - JIDX_W - SH;

  logic [XLEN-1:0] off_bytes;

  // target add runs beside the register read; only the compare waits for it
  assign off_bytes = {{EXT_W{imm_i[IMM_W-1]}}, imm_i, {SH{1'b0}}};
  assign br_tgt_o  = pc_plus4_i + off_bytes;
  assign jmp_tgt_o = {pc_plus4_i[XLEN-1 -: PAGE_W], jidx_i, {SH{1'b0}}};
endmodule

// File: rtl/hz_resolve.sv
module hz_resolve
  import hz_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  id_cls_e cls_i,
  input  logic    ops_equal_i,
  input  logic    pred_taken_i,
  input  logic    stall_i,
  output logic    flush_o,
  output pc_sel_e sel_o
);
  logic is_branch, taken;

  assign is_branch = (cls_i == CLS_BEQ) || (cls_i == CLS_BNE);
  assign taken     = ((cls_i == CLS_BEQ) && ops_equal_i) ||
                     ((cls_i == CLS_BNE) && !ops_equal_i);

  always_comb begin
    flush_o = 1'b0;
    sel_o   = SEL_SEQ;
    if (!stall_i) begin
      if (cls_i == CLS_JMP) begin
        flush_o = 1'b1;
        sel_o   = SEL_JMP;
      end else if (is_branch && taken && !pred_taken_i) begin
        flush_o = 1'b1;
        sel_o   = SEL_BR;
      end else if (is_branch && !taken && pred_taken_i) begin
        flush_o = 1'b1;
        sel_o   = SEL_FIX;
      end
    end
  end

  // R10: ordinary instructions never redirect
  p_other_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cls_i == CLS_OTHER) |-> (!flush_o && sel_o == SEL_SEQ));
  // R3: an unstalled jump always squashes
  p_jump_squash_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cls_i == CLS_JMP && !stall_i) |-> (flush_o && sel_o == SEL_JMP));
  // R6: a correct taken prediction costs nothing
  p_pred_hit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_branch && taken && pred_taken_i) |-> !flush_o);
endmodule

// File: rtl/hz_ctrl_top.sv
module hz_ctrl_top
  import hz_pkg::*;
#(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned REG_AW = 5,
  parameter int unsigned IMM_W  = 16,
  parameter int unsigned JIDX_W = 26
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        id_class_i,
  input  logic              id_ops_equal_i,
  input  logic              id_pred_taken_i,
  input  logic [REG_AW-1:0] id_rs_i,
  input  logic [REG_AW-1:0] id_rt_i,
  input  logic [XLEN-1:0]   id_pc_plus4_i,
  input  logic [IMM_W-1:0]  id_imm_i,
  input  logic [JIDX_W-1:0] id_jidx_i,
  input  logic              ex_mem_read_i,
  input  logic [REG_AW-1:0] ex_rt_i,
  output logic              pc_we_o,
  output logic              ifid_we_o,
  output logic              ifid_flush_o,
  output logic              idex_bubble_o,
  output logic [1:0]        pc_sel_o,
  output logic [XLEN-1:0]   redirect_pc_o
);
  logic            stall;
  logic            flush;
  pc_sel_e         sel;
  logic [XLEN-1:0] br_tgt, jmp_tgt;

  hz_loaduse #(.REG_AW(REG_AW)) u_loaduse (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .ex_mem_read_i (ex_mem_read_i),
    .ex_rt_i       (ex_rt_i),
    .id_rs_i       (id_rs_i),
    .id_rt_i       (id_rt_i),
    .stall_o       (stall)
  );

  hz_target #(.XLEN(XLEN), .IMM_W(IMM_W), .JIDX_W(JIDX_W)) u_target (
    .pc_plus4_i (id_pc_plus4_i),
    .imm_i      (id_imm_i),
    .jidx_i     (id_jidx_i),
    .br_tgt_o   (br_tgt),
    .jmp_tgt_o  (jmp_tgt)
  );

  hz_resolve u_resolve (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cls_i        (id_cls_e'(id_class_i)),
    .ops_equal_i  (id_ops_equal_i),
    .pred_taken_i (id_pred_taken_i),
    .stall_i      (stall),
    .flush_o      (flush),
    .sel_o        (sel)
  );

  // in-place stall: freeze front, bubble into execute
  assign pc_we_o       = !stall;
  assign ifid_we_o     = !stall;
  assign idex_bubble_o = stall;
  assign ifid_flush_o  = flush;
  assign pc_sel_o      = sel;

  always_comb begin
    unique case (sel)
      SEL_BR:  redirect_pc_o = br_tgt;
      SEL_JMP: redirect_pc_o = jmp_tgt;
      default: redirect_pc_o = id_pc_plus4_i;
    endcase
  end

  // R1: a bubble always comes with a frozen front end
  p_freeze_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idex_bubble_o |-> (!pc_we_o && !ifid_we_o));
  // R8: stall beats redirect
  p_stall_first_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idex_bubble_o |-> (!ifid_flush_o && pc_sel_o == 2'd0));
  // R9: squash and redirect travel together
  p_flush_redirect_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ifid_flush_o == (pc_sel_o != 2'd0));
endmodule

// File: tb/tb_hz_ctrl_top.sv
module tb_hz_ctrl_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  id_class_i = '0;
  logic        id_ops_equal_i = 1'b0;
  logic        id_pred_taken_i = 1'b0;
  logic [4:0]  id_rs_i = '0;
  logic [4:0]  id_rt_i = '0;
  logic [31:0] id_pc_plus4_i = '0;
  logic [15:0] id_imm_i = '0;
  logic [25:0] id_jidx_i = '0;
  logic        ex_mem_read_i = 1'b0;
  logic [4:0]  ex_rt_i = '0;
  logic        pc_we_o, ifid_we_o, ifid_flush_o, idex_bubble_o;
  logic [1:0]  pc_sel_o;
  logic [31:0] redirect_pc_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #5 clk_i = ~clk_i;

  hz_ctrl_top dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] cls, input logic eq, input logic pred,
                       input logic mr, input logic [4:0] xrt,
                       input logic [4:0] rs, input logic [4:0] rt);
    @(negedge clk_i);
    id_class_i = cls; id_ops_equal_i = eq; id_pred_taken_i = pred;
    ex_mem_read_i = mr; ex_rt_i = xrt; id_rs_i = rs; id_rt_i = rt;
    #1;
  endtask

  task automatic expect_ctl(input string req, input logic we, input logic fl,
                            input logic [1:0] sel);
    chk({req, " pc_we"}, {31'd0, pc_we_o}, {31'd0, we});
    chk({req, " ifid_we"}, {31'd0, ifid_we_o}, {31'd0, we});
    chk({req, " bubble"}, {31'd0, idex_bubble_o}, {31'd0, !we});
    chk({req, " flush"}, {31'd0, ifid_flush_o}, {31'd0, fl});
    chk({req, " sel"}, {30'd0, pc_sel_o}, {30'd0, sel});
  endtask

  function automatic logic [31:0] br_exp(input logic [31:0] p4, input logic [15:0] im);
    return p4 + {{14{im[15]}}, im, 2'b00};
  endfunction

  task automatic t_reset();
    #1;
    expect_ctl("R2 reset", 1'b1, 1'b0, 2'd0);
  endtask

  task automatic t_load_use();
    drive(2'd0, 0, 0, 1, 5'd7, 5'd7, 5'd3);
    expect_ctl("R1 rs match", 1'b0, 1'b0, 2'd0);
    drive(2'd0, 0, 0, 1, 5'd9, 5'd2, 5'd9);
    expect_ctl("R1 rt match", 1'b0, 1'b0, 2'd0);
  endtask

  task automatic t_no_hazard();
    drive(2'd0, 0, 0, 1, 5'd0, 5'd0, 5'd0);
    expect_ctl("R2 zero dest", 1'b1, 1'b0, 2'd0);
    drive(2'd0, 0, 0, 0, 5'd7, 5'd7, 5'd7);
    expect_ctl("R2 not load", 1'b1, 1'b0, 2'd0);
    drive(2'd0, 0, 0, 1, 5'd7, 5'd6, 5'd8);
    expect_ctl("R2 no match", 1'b1, 1'b0, 2'd0);
  endtask

  task automatic t_jump();
    id_pc_plus4_i = 32'hA000_1004; id_jidx_i = 26'h2AB_CDEF;
    drive(2'd3, 0, 0, 0, 5'd0, 5'd1, 5'd2);
    expect_ctl("R3 jump", 1'b1, 1'b1, 2'd2);
    chk("R3 jump target", redirect_pc_o, {4'hA, 26'h2AB_CDEF, 2'b00});
  endtask

  task automatic t_branch_taken();
    id_pc_plus4_i = 32'h0000_2000; id_imm_i = 16'h0010;
    drive(2'd1, 1, 0, 0, 5'd0, 5'd1, 5'd2);
    expect_ctl("R4 beq taken", 1'b1, 1'b1, 2'd1);
    chk("R4 fwd target", redirect_pc_o, br_exp(32'h0000_2000, 16'h0010));
    id_imm_i = 16'hFFF8;
    drive(2'd2, 0, 0, 0, 5'd0, 5'd1, 5'd2);
    expect_ctl("R4 bne taken", 1'b1, 1'b1, 2'd1);
    chk("R4 back target", redirect_pc_o, 32'h0000_1FE0);
  endtask

  task automatic t_branch_not_taken();
    id_pc_plus4_i = 32'h0000_3000;
    drive(2'd1, 0, 0, 0, 5'd0, 5'd1, 5'd2);
    expect_ctl("R5 beq fall", 1'b1, 1'b0, 2'd0);
    drive(2'd2, 1, 0, 0, 5'd0, 5'd1, 5'd2);
    expect_ctl("R5 bne fall", 1'b1, 1'b0, 2'd0);
  endtask

  task automatic t_pred_hit();
    drive(2'd1, 1, 1, 0, 5'd0, 5'd1, 5'd2);
    expect_ctl("R6 beq hit", 1'b1, 1'b0, 2'd0);
    drive(2'd2, 0, 1, 0, 5'd0, 5'd1, 5'd2);
    expect_ctl("R6 bne hit", 1'b1, 1'b0, 2'd0);
  endtask

  task automatic t_pred_miss();
    id_pc_plus4_i = 32'h0000_4444; id_imm_i = 16'h0100;
    drive(2'd1, 0, 1, 0, 5'd0, 5'd1, 5'd2);
    expect_ctl("R7 repair", 1'b1, 1'b1, 2'd3);
    chk("R7 repair pc", redirect_pc_o, 32'h0000_4444);
    drive(2'd0, 0, 0, 0, 5'd0, 5'd1, 5'd2);
    chk("R7 seq pc", redirect_pc_o, 32'h0000_4444);
  endtask

  task automatic t_priority();
    id_pc_plus4_i = 32'h0000_5000; id_imm_i = 16'h0004;
    drive(2'd1, 1, 0, 1, 5'd4, 5'd4, 5'd5);
    expect_ctl("R8 stall wins", 1'b0, 1'b0, 2'd0);
    drive(2'd1, 1, 0, 0, 5'd4, 5'd4, 5'd5);
    expect_ctl("R8 resolves after", 1'b1, 1'b1, 2'd1);
    chk("R8 target after", redirect_pc_o, 32'h0000_5010);
    drive(2'd3, 0, 0, 1, 5'd6, 5'd1, 5'd6);
    expect_ctl("R9 jump stalled", 1'b0, 1'b0, 2'd0);
  endtask

  task automatic t_other();
    for (int k = 0; k < 4; k++) begin
      drive(2'd0, k[0], k[1], 0, 5'd0, 5'd1, 5'd2);
      expect_ctl("R10 other", 1'b1, 1'b0, 2'd0);
    end
  endtask

  initial begin
    t_reset();
    repeat (2) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
    t_load_use();
    t_no_hazard();
    t_jump();
    t_branch_taken();
    t_branch_not_taken();
    t_pred_hit();
    t_pred_miss();
    t_priority();
    t_other();
    @(negedge clk_i);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end
endmodule